// File: doc/BRIEF.md
# Addressed Shift-Register Latch Dispatcher

This block owns a 40-bit serial word register and a small set of destinations behind it. Host logic shifts a word in one bit at a time, most significant bit first. It then raises a latch strobe. The top nibble of the word is an address, and it decides what happens to the remaining 36 bits. The payload can be copied into one of three parallel latches: grayscale, dot-correction, or function/brightness control. The block can also clear a fault-induced shutdown. It can issue a program request toward one of two nonvolatile banks, but only when the correct 8-bit key is present. Finally, it can replace the register contents with a readable word, either the status word or the nonvolatile read data, so that the host can clock that word back out.

Every action happens in the single clock cycle that follows a rising edge of the strobe. A strobe that stays high therefore acts only once. The serial output always shows the register's current top bit. A word that was loaded for reading comes out in full after 40 shift enables. The dot-correction latch takes its value from the nonvolatile default input when reset is applied.

Top module: `addr_shift_dispatch`

## Requirements
- R1: After synchronous reset, the grayscale and function/brightness latches hold zero, the dot-correction latch equals `nvm_dc_default`, `drive_enable` is 1, both program requests are 0, and `sdo` is 0.
- R2: On each clock with `shift_en` high, the register shifts left and takes `sdi` into bit 0. `sdo` is bit 39. A word shifted in is returned unchanged, MSB first, by the next 40 shifts.
- R3: Address 0 (bits 39:36 = 0000) copies bits 35:0 into `gs_data`.
- R4: Addresses 1 to 8 change no latch, no program request, and not `drive_enable`.
- R5: Address 9 sets `drive_enable` back to 1 after a fault. When no fault has occurred, it changes nothing.
- R6: A high `ovp_fault` or `scp_fault` clears `drive_enable` on the next clock. Only address 9 sets it again.
- R7: Address 10 loads `status_word` into the register so that it can be shifted out.
- R8: Address 11 loads `nvm_rdata` into the register so that it can be shifted out.
- R9: Address 12 raises `nvm_prog_bank1` for one cycle, with `nvm_prog_data` set to bits 27:0, only when bits 35:28 equal A5h. With any other key, no request is raised.
- R10: Address 13 raises `nvm_prog_bank2` for one cycle, with `nvm_prog_data` set to bits 27:0, only when bits 35:28 equal 5Ah.
- R11: Address 14 copies bits 35:0 into `dc_data`. Address 15 copies them into `fcbc_data`.
- R12: Each rising edge of `latch_req` causes exactly one transfer, in the next clock cycle. A strobe held high repeats nothing. At most one program request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift one bit on this clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (register MSB) |
| latch_req | input | 1 | Latch strobe; its rising edge triggers a transfer |
| ovp_fault | input | 1 | Overvoltage fault indication |
| scp_fault | input | 1 | Short-circuit fault indication |
| status_word | input | 40 | Word loaded by a status read |
| nvm_rdata | input | 40 | Nonvolatile read data |
| nvm_dc_default | input | 36 | Stored dot-correction default, loaded at reset |
| gs_data | output | 36 | Grayscale latch |
| dc_data | output | 36 | Dot-correction latch |
| fcbc_data | output | 36 | Function/brightness control latch |
| drive_enable | output | 1 | Low while shut down by a fault |
| nvm_prog_bank1 | output | 1 | One-cycle program request, bank 1 |
| nvm_prog_bank2 | output | 1 | One-cycle program request, bank 2 |
| nvm_prog_data | output | 28 | Data accompanying a program request |

## Verification
The bench builds the block with its default widths: a 40-bit word, a 4-bit address and an 8-bit key. At these values every one of the sixteen address codes can be reached, including unassigned ones. Both key values can be applied, as well as near-miss and swapped keys. A full 40-bit readback completes in a few dozen cycles. Together these cover the fault/restart ordering, the guarded program path and a held strobe.

// File: rtl/asr_pkg.sv
package asr_pkg;

    localparam int WORD_W = 40;
    localparam int ADDR_W = 4;
    localparam int KEY_W  = 8;
    localparam int PAY_W  = WORD_W - ADDR_W;
    localparam int DATA_W = PAY_W - KEY_W;

    localparam logic [KEY_W-1:0] KEY_BANK1 = 8'hA5;
    localparam logic [KEY_W-1:0] KEY_BANK2 = 8'h5A;

    typedef enum logic [ADDR_W-1:0] {
        DST_GRAY    = 4'd0,
        DST_RESTART = 4'd9,
        DST_STATUS  = 4'd10,
        DST_NVREAD  = 4'd11,
        DST_NVPROG1 = 4'd12,
        DST_NVPROG2 = 4'd13,
        DST_DOTCORR = 4'd14,
        DST_FUNCBR  = 4'd15
    } dest_e;

    typedef struct packed {
        logic gs_we;
        logic dc_we;
        logic fc_we;
        logic restart;
        logic ld_status;
        logic ld_nvm;
        logic prog1;
        logic prog2;
    } xfer_t;

    function automatic xfer_t decode_dest(logic [ADDR_W-1:0] a, logic [KEY_W-1:0] key);
        xfer_t c;
        c = '0;
        case (a)
            DST_GRAY:    c.gs_we     = 1'b1;
            DST_RESTART: c.restart   = 1'b1;
            DST_STATUS:  c.ld_status = 1'b1;
            DST_NVREAD:  c.ld_nvm    = 1'b1;
            DST_NVPROG1: c.prog1     = (key == KEY_BANK1);
            DST_NVPROG2: c.prog2     = (key == KEY_BANK2);
            DST_DOTCORR: c.dc_we     = 1'b1;
            DST_FUNCBR:  c.fc_we     = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/asr_shifter.sv
module asr_shifter
    import asr_pkg::*;
#(
    parameter int WIDTH = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             sdi,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] q,
    output logic             sdo
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_word;
        else if (shift_en)
            q <= {q[WIDTH-2:0], sdi};
    end

    assign sdo = q[WIDTH-1];

    // R2: a shift without a load takes the serial input into bit 0
    a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load) |=> (q[0] == $past(sdi)));

    // R7 / R8: a load places the selected readable word in the register
    a_r7_load_word: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(load_word)));

endmodule

// File: rtl/asr_decoder.sv
module asr_decoder
    import asr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  key,
    output xfer_t             cmd
);

    logic strobe_d;
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_d <= latch_req;
            strobe_q <= latch_req && !strobe_d;
        end
    end

    always_comb begin
        cmd = '0;
        if (strobe_q)
            cmd = decode_dest(addr, key);
    end

    // R12: a transfer cycle is never immediately followed by another
    a_r12_single_xfer: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);

    // R12: at most one action per transfer
    a_r12_one_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd));

endmodule

// File: rtl/asr_latches.sv
module asr_latches
    import asr_pkg::*;
#(
    parameter int PW = PAY_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_t         cmd,
    input  logic [PW-1:0] payload,
    input  logic          ovp,
    input  logic          scp,
    input  logic [PW-1:0] dc_default,
    output logic [PW-1:0] gs_q,
    output logic [PW-1:0] dc_q,
    output logic [PW-1:0] fc_q,
    output logic          en_q,
    output logic          prog1_q,
    output logic          prog2_q,
    output logic [DW-1:0] pdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gs_q    <= '0;
            dc_q    <= dc_default;
            fc_q    <= '0;
            en_q    <= 1'b1;
            prog1_q <= 1'b0;
            prog2_q <= 1'b0;
            pdata_q <= '0;
        end else begin
            if (cmd.gs_we) gs_q <= payload;
            if (cmd.dc_we) dc_q <= payload;
            if (cmd.fc_we) fc_q <= payload;
            if (ovp || scp)
                en_q <= 1'b0;
            else if (cmd.restart)
                en_q <= 1'b1;
            prog1_q <= cmd.prog1;
            prog2_q <= cmd.prog2;
            if (cmd.prog1 || cmd.prog2)
                pdata_q <= payload[DW-1:0];
        end
    end

    // R6: a fault shuts the outputs down on the next clock
    a_r6_fault_disables: assert property (@(posedge clk) disable iff (rst)
        (ovp || scp) |=> !en_q);

    // R5: restart with no fault present re-enables
    a_r5_restart_enables: assert property (@(posedge clk) disable iff (rst)
        (cmd.restart && !ovp && !scp) |=> en_q);

    // R4: the grayscale latch holds when not written
    a_r4_gs_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd.gs_we |=> $stable(gs_q));

    // R9 / R10: program requests are single-cycle and exclusive
    a_r9_prog_pulse: assert property (@(posedge clk) disable iff (rst)
        (prog1_q || prog2_q) |=> !(prog1_q || prog2_q));

    a_r10_prog_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog1_q, prog2_q}));

endmodule

// File: rtl/addr_shift_dispatch.sv
module addr_shift_dispatch
    import asr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              sdi,
    output logic              sdo,
    input  logic              latch_req,
    input  logic              ovp_fault,
    input  logic              scp_fault,
    input  logic [WORD_W-1:0] status_word,
    input  logic [WORD_W-1:0] nvm_rdata,
    input  logic [PAY_W-1:0]  nvm_dc_default,
    output logic [PAY_W-1:0]  gs_data,
    output logic [PAY_W-1:0]  dc_data,
    output logic [PAY_W-1:0]  fcbc_data,
    output logic              drive_enable,
    output logic              nvm_prog_bank1,
    output logic              nvm_prog_bank2,
    output logic [DATA_W-1:0] nvm_prog_data
);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] load_word;
    logic              load;
    xfer_t             cmd;

    assign load      = cmd.ld_status || cmd.ld_nvm;
    assign load_word = cmd.ld_status ? status_word : nvm_rdata;

    asr_shifter #(.WIDTH(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .sdi       (sdi),
        .load      (load),
        .load_word (load_word),
        .q         (word_q),
        .sdo       (sdo)
    );

    asr_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .latch_req (latch_req),
        .addr      (word_q[WORD_W-1 -: ADDR_W]),
        .key       (word_q[PAY_W-1 -: KEY_W]),
        .cmd       (cmd)
    );

    asr_latches #(.PW(PAY_W), .DW(DATA_W)) u_lat (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .payload    (word_q[PAY_W-1:0]),
        .ovp        (ovp_fault),
        .scp        (scp_fault),
        .dc_default (nvm_dc_default),
        .gs_q       (gs_data),
        .dc_q       (dc_data),
        .fc_q       (fcbc_data),
        .en_q       (drive_enable),
        .prog1_q    (nvm_prog_bank1),
        .prog2_q    (nvm_prog_bank2),
        .pdata_q    (nvm_prog_data)
    );

endmodule

// File: tb/addr_shift_dispatch_test.sv
`timescale 1ns/1ps
module addr_shift_dispatch_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shift_en = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        latch_req = 1'b0;
    logic        ovp_fault = 1'b0;
    logic        scp_fault = 1'b0;
    logic [39:0] status_word = 40'hA1B2C3D4E5;
    logic [39:0] nvm_rdata   = 40'h5F00DEC0DE;
    logic [35:0] nvm_dc_default = 36'hF0E1D2C3B;
    logic [35:0] gs_data, dc_data, fcbc_data;
    logic        drive_enable, nvm_prog_bank1, nvm_prog_bank2;
    logic [27:0] nvm_prog_data;

    always #4 clk = ~clk;

    addr_shift_dispatch uut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sdi(sdi), .sdo(sdo),
        .latch_req(latch_req), .ovp_fault(ovp_fault), .scp_fault(scp_fault),
        .status_word(status_word), .nvm_rdata(nvm_rdata),
        .nvm_dc_default(nvm_dc_default), .gs_data(gs_data), .dc_data(dc_data),
        .fcbc_data(fcbc_data), .drive_enable(drive_enable),
        .nvm_prog_bank1(nvm_prog_bank1), .nvm_prog_bank2(nvm_prog_bank2),
        .nvm_prog_data(nvm_prog_data)
    );

    typedef struct {
        string       req;
        logic [35:0] gs, dc, fc;
        logic        en, p1, p2;
        logic        chk_pd;
        logic [27:0] pd;
        logic        chk_rd;
        logic [39:0] rd;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;
    logic [35:0] m_gs = '0, m_dc = '0, m_fc = '0;
    logic        m_en = 1'b1;
    logic [39:0] rd_word = '0;

    task automatic expect_now(string req, bit p1, bit p2, bit chk_pd, logic [27:0] pd,
                              bit chk_rd, logic [39:0] rd);
        exp_t e;
        e.req = req; e.gs = m_gs; e.dc = m_dc; e.fc = m_fc; e.en = m_en;
        e.p1 = p1; e.p2 = p2; e.chk_pd = chk_pd; e.pd = pd;
        e.chk_rd = chk_rd; e.rd = rd;
        sb.push_back(e);
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            exp_t e;
            bit   bad;
            wait (sb.size() > 0);
            e = sb.pop_front();
            checks++;
            bad = (gs_data !== e.gs) || (dc_data !== e.dc) || (fcbc_data !== e.fc) ||
                  (drive_enable !== e.en) || (nvm_prog_bank1 !== e.p1) ||
                  (nvm_prog_bank2 !== e.p2) ||
                  (e.chk_pd && (nvm_prog_data !== e.pd)) ||
                  (e.chk_rd && (rd_word !== e.rd));
            if (bad) begin
                fails++;
                $display("FAIL %s: act gs=%h dc=%h fc=%h en=%b p1=%b p2=%b pd=%h rd=%h",
                         e.req, gs_data, dc_data, fcbc_data, drive_enable,
                         nvm_prog_bank1, nvm_prog_bank2, nvm_prog_data, rd_word);
                $display("     %s: exp gs=%h dc=%h fc=%h en=%b p1=%b p2=%b pd=%h rd=%h",
                         e.req, e.gs, e.dc, e.fc, e.en, e.p1, e.p2, e.pd, e.rd);
            end
        end
    end

    task automatic shift_word(logic [39:0] w);
        for (int i = 39; i >= 0; i--) begin
            sdi = w[i];
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
        sdi = 1'b0;
    endtask

    task automatic read_word();
        for (int i = 39; i >= 0; i--) begin
            rd_word[i] = sdo;
            sdi = 1'b0;
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
    endtask

    // strobe rises at N0, falls at N1, transfer lands at the edge after N1
    task automatic strobe();
        latch_req = 1'b1;
        @(negedge clk);
        latch_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(logic [39:0] w);
        shift_word(w);
        strobe();
    endtask

    task automatic fault_pulse(bit ov);
        if (ov) ovp_fault = 1'b1; else scp_fault = 1'b1;
        @(negedge clk);
        ovp_fault = 1'b0;
        scp_fault = 1'b0;
        m_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_dc = nvm_dc_default;
        // R1: reset state
        if (sdo !== 1'b0) begin
            checks++; fails++;
            $display("FAIL R1: sdo act=%b exp=0", sdo);
        end
        expect_now("R1 reset state", 0, 0, 0, '0, 0, '0);
        @(negedge clk);

        // R2: echo through the register, unassigned address 3
        shift_word({4'h3, 36'h9_8765_4321});
        read_word();
        expect_now("R2 serial echo", 0, 0, 0, '0, 1, {4'h3, 36'h9_8765_4321});

        // R3: grayscale write
        send({4'h0, 36'h1_2345_6789});
        m_gs = 36'h1_2345_6789;
        expect_now("R3 grayscale write", 0, 0, 0, '0, 0, '0);

        // R4: unassigned addresses change nothing
        send({4'h5, 8'hA5, 28'h7777777});
        expect_now("R4 address 5 ignored", 0, 0, 0, '0, 0, '0);
        send({4'h1, 36'hF_FFFF_FFFF});
        expect_now("R4 address 1 ignored", 0, 0, 0, '0, 0, '0);
        send({4'h8, 36'h0_0000_0001});
        expect_now("R4 address 8 ignored", 0, 0, 0, '0, 0, '0);

        // R5: restart while running changes nothing
        send({4'h9, 36'h0_0000_0000});
        expect_now("R5 restart while running", 0, 0, 0, '0, 0, '0);

        // R6: overvoltage shuts down; unassigned address does not restart
        fault_pulse(1'b1);
        expect_now("R6 overvoltage disables", 0, 0, 0, '0, 0, '0);
        send({4'h3, 36'h0_0000_0009});
        expect_now("R6 still disabled after address 3", 0, 0, 0, '0, 0, '0);
        send({4'h9, 36'hA_BCDE_F012});
        m_en = 1'b1;
        expect_now("R5 restart after overvoltage", 0, 0, 0, '0, 0, '0);
        fault_pulse(1'b0);
        expect_now("R6 short-circuit disables", 0, 0, 0, '0, 0, '0);
        send({4'h9, 36'h0});
        m_en = 1'b1;
        expect_now("R5 restart after short-circuit", 0, 0, 0, '0, 0, '0);

        // R11: dot-correction and function/brightness latches
        send({4'hE, 36'h3_3C3C_3C3C});
        m_dc = 36'h3_3C3C_3C3C;
        expect_now("R11 dot-correction write", 0, 0, 0, '0, 0, '0);
        send({4'hF, 36'hC_0FFE_E123});
        m_fc = 36'hC_0FFE_E123;
        expect_now("R11 function/brightness write", 0, 0, 0, '0, 0, '0);

        // R9: bank 1 program with correct key, then pulse ends
        send({4'hC, 8'hA5, 28'hABCDEF1});
        expect_now("R9 bank1 program", 1, 0, 1, 28'hABCDEF1, 0, '0);
        @(negedge clk);
        expect_now("R9 bank1 request one cycle", 0, 0, 0, '0, 0, '0);
        send({4'hC, 8'hA4, 28'h1111111});
        expect_now("R9 bank1 wrong key", 0, 0, 0, '0, 0, '0);
        send({4'hC, 8'h5A, 28'h2222222});
        expect_now("R9 bank1 swapped key", 0, 0, 0, '0, 0, '0);

        // R10: bank 2 program
        send({4'hD, 8'h5A, 28'h1234567});
        expect_now("R10 bank2 program", 0, 1, 1, 28'h1234567, 0, '0);
        send({4'hD, 8'hA5, 28'h7654321});
        expect_now("R10 bank2 wrong key", 0, 0, 0, '0, 0, '0);

        // R7: status read-back
        send({4'hA, 36'h0});
        read_word();
        expect_now("R7 status read-back", 0, 0, 0, '0, 1, status_word);

        // R8: nonvolatile read-back
        send({4'hB, 36'h0});
        read_word();
        expect_now("R8 nonvolatile read-back", 0, 0, 0, '0, 1, nvm_rdata);

        // R12: held strobe acts once
        shift_word({4'hC, 8'hA5, 28'h0C0FFEE});
        latch_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_now("R12 held strobe first transfer", 1, 0, 1, 28'h0C0FFEE, 0, '0);
        @(negedge clk);
        expect_now("R12 held strobe no repeat", 0, 0, 0, '0, 0, '0);
        @(negedge clk);
        expect_now("R12 held strobe still idle", 0, 0, 0, '0, 0, '0);
        latch_req = 1'b0;
        @(negedge clk);

        wait (sb.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: act=expired exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule